// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block is the interrupt logic for one bank of up to 32 general-purpose pins. The pins reach it already synchronized to the clock. Three configuration words choose how each pin is watched, one bit per pin in each word:

- A kind bit chooses edge or level detection.
- A sense bit chooses rising edge or high level (1), or falling edge or low level (0).
- A dual-edge bit makes an edge pin fire on both transitions.

Detected events are latched into a sticky status word. Software clears status bits by writing 1s to them.

A per-pin block word gates whether a latched event reaches the single bank interrupt output. Software never writes the block word directly. Writing 1s to an unblock port clears block bits, and writing 1s to a block port sets them, so one pin can be changed without a read-modify-write. Detection runs whether or not a pin is blocked. An event caught while a pin is blocked therefore raises the interrupt as soon as the pin is unblocked.

Register access uses a plain 32-bit bus with no back-pressure. A write takes effect on the clock edge where `bus_en` and `bus_we` are high. Read data is combinational from the address while `bus_en` is high and `bus_we` is low; it reads 0 otherwise.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the block word reads all 1s, status reads 0, the kind and sense words read all 1s, the dual-edge word reads 0 (every pin on rising edge), and `irq_o` is 0.
- R2: The byte addresses are: block word 0x20C, unblock port 0x210, block port 0x214, status 0x218, kind 0x21C, sense 0x220 and dual-edge 0x224, each plus 0x40×BANK. Reads of the unblock and block ports return 0. Writes to the block word address are ignored.
- R3: With kind=1, sense=1 and dual-edge=0, a 0→1 pin transition sets the pin's status bit. The bit is readable after the clock edge that first samples the new level. A 1→0 transition sets nothing.
- R4: With kind=1, sense=0 and dual-edge=0, a 1→0 transition sets the status bit and a 0→1 transition does not.
- R5: With kind=1 and dual-edge=1, both transitions set the status bit, whatever the sense bit holds.
- R6: With kind=0, the status bit is set while the pin is at the level chosen by the sense bit (1 = high, 0 = low). The dual-edge bit has no effect.
- R7: Writing the status address clears each bit written as 1. Bits written as 0 keep their value.
- R8: A level-kind pin whose active level is still present reads 1 in status after a clearing write.
- R9: An edge detected in the same cycle as a clearing write to that bit leaves the bit set.
- R10: A 1 written to the unblock port clears that block bit, and a 1 written to the block port sets it. Bits written as 0 leave the block word unchanged.
- R11: A blocked pin still latches events into status. Unblocking it raises `irq_o` with no new event.
- R12: `irq_o` is 1 exactly when some status bit is 1 and its block bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | NPINS | Synchronized pin levels |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Bank interrupt |

## Verification
Detection is exercised with the following pin patterns:

- Rising and falling transitions on pins configured for a single edge, which shows that the sense bit picks one direction and rejects the other.
- Both transitions on dual-edge pins, with the sense bit set and cleared, which shows that the sense bit is ignored in that mode.
- Static high and low levels on level pins, held across a clearing write. This separates sticky re-detection from a one-shot latch.
- An edge that coincides with a clearing write, which shows that a new event takes priority over the clear.
- Events on blocked pins followed by unblocking, which separates gating of propagation from gating of detection.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFF_BLOCK   = 32'h20C;
  localparam int OFF_UNBLK_P = 32'h210;
  localparam int OFF_BLK_P   = 32'h214;
  localparam int OFF_STATUS  = 32'h218;
  localparam int OFF_KIND    = 32'h21C;
  localparam int OFF_SENSE   = 32'h220;
  localparam int OFF_DUAL    = 32'h224;
  localparam int BANK_STRIDE = 32'h40;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BLOCK, SEL_UNBLK, SEL_BLK, SEL_STATUS, SEL_KIND, SEL_SENSE, SEL_DUAL
  } reg_sel_e;

  function automatic int reg_addr(input int bank, input int off);
    return off + bank * BANK_STRIDE;
  endfunction
endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_BLOCK  = ADDR_W'(reg_addr(BANK, OFF_BLOCK));
  localparam logic [ADDR_W-1:0] A_UNBLK  = ADDR_W'(reg_addr(BANK, OFF_UNBLK_P));
  localparam logic [ADDR_W-1:0] A_BLK    = ADDR_W'(reg_addr(BANK, OFF_BLK_P));
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(reg_addr(BANK, OFF_STATUS));
  localparam logic [ADDR_W-1:0] A_KIND   = ADDR_W'(reg_addr(BANK, OFF_KIND));
  localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(reg_addr(BANK, OFF_SENSE));
  localparam logic [ADDR_W-1:0] A_DUAL   = ADDR_W'(reg_addr(BANK, OFF_DUAL));

  always_comb begin
    if      (addr == A_BLOCK)  sel = SEL_BLOCK;
    else if (addr == A_UNBLK)  sel = SEL_UNBLK;
    else if (addr == A_BLK)    sel = SEL_BLK;
    else if (addr == A_STATUS) sel = SEL_STATUS;
    else if (addr == A_KIND)   sel = SEL_KIND;
    else if (addr == A_SENSE)  sel = SEL_SENSE;
    else if (addr == A_DUAL)   sel = SEL_DUAL;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_kind,
  input  logic             wr_sense,
  input  logic             wr_dual,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] kind_q,
  output logic [NPINS-1:0] sense_q,
  output logic [NPINS-1:0] dual_q
);
  // Reset leaves every pin on rising-edge detection so that status stays quiet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '1;
      sense_q <= '1;
      dual_q  <= '0;
    end else begin
      if (wr_kind)  kind_q  <= wdata;
      if (wr_sense) sense_q <= wdata;
      if (wr_dual)  dual_q  <= wdata;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] kind_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] dual_i,
  output logic [NPINS-1:0] event_o
);
  logic [NPINS-1:0] prev_q;
  logic             primed_q;

  // The first sampled level after reset is only a reference, never an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, edge_hit, level_hit;
    assign rise      = primed_q & pin_i[i] & ~prev_q[i];
    assign fall      = primed_q & ~pin_i[i] & prev_q[i];
    assign edge_hit  = dual_i[i] ? (rise | fall) : (sense_i[i] ? rise : fall);
    assign level_hit = sense_i[i] ? pin_i[i] : ~pin_i[i];
    assign event_o[i] = kind_i[i] ? edge_hit : level_hit;
  end
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] unblk_i,
  input  logic [NPINS-1:0] blk_i,
  output logic [NPINS-1:0] status_q,
  output logic [NPINS-1:0] block_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      block_q  <= '1;
    end else begin
      // A new event wins over a clear of the same bit.
      status_q <= (status_q & ~clr_i) | event_i;
      block_q  <= (block_q & ~unblk_i) | blk_i;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BANK   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             wr;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] kind_q, sense_q, dual_q;
  logic [NPINS-1:0] events;
  logic [NPINS-1:0] clr_bits, unblk_bits, blk_bits;
  logic [NPINS-1:0] sts_q, mask_q;

  gpio_irq_decode #(.ADDR_W(ADDR_W), .BANK(BANK)) dec_i (
    .addr(bus_addr), .sel(sel)
  );

  assign wr = bus_en & bus_we;
  assign wd = bus_wdata[NPINS-1:0];

  assign clr_bits   = (wr && sel == SEL_STATUS) ? wd : '0;
  assign unblk_bits = (wr && sel == SEL_UNBLK)  ? wd : '0;
  assign blk_bits   = (wr && sel == SEL_BLK)    ? wd : '0;

  gpio_irq_cfg #(.NPINS(NPINS)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .wr_kind (wr && sel == SEL_KIND),
    .wr_sense(wr && sel == SEL_SENSE),
    .wr_dual (wr && sel == SEL_DUAL),
    .wdata(wd), .kind_q(kind_q), .sense_q(sense_q), .dual_q(dual_q)
  );

  gpio_irq_detect #(.NPINS(NPINS)) det_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .kind_i(kind_q), .sense_i(sense_q), .dual_i(dual_q), .event_o(events)
  );

  gpio_irq_latch #(.NPINS(NPINS)) lat_i (
    .clk(clk), .rst_n(rst_n), .event_i(events), .clr_i(clr_bits),
    .unblk_i(unblk_bits), .blk_i(blk_bits), .status_q(sts_q), .block_q(mask_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (sel)
        SEL_BLOCK:  bus_rdata = DATA_W'(mask_q);
        SEL_STATUS: bus_rdata = DATA_W'(sts_q);
        SEL_KIND:   bus_rdata = DATA_W'(kind_q);
        SEL_SENSE:  bus_rdata = DATA_W'(sense_q);
        SEL_DUAL:   bus_rdata = DATA_W'(dual_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = |(sts_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BANK   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  sts,
  input logic [NPINS-1:0]  mask,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] C_UNBLK  = ADDR_W'(reg_addr(BANK, OFF_UNBLK_P));
  localparam logic [ADDR_W-1:0] C_BLK    = ADDR_W'(reg_addr(BANK, OFF_BLK_P));
  localparam logic [ADDR_W-1:0] C_STATUS = ADDR_W'(reg_addr(BANK, OFF_STATUS));

  logic             w_unblk, w_blk, w_sts;
  logic [NPINS-1:0] d;
  assign w_unblk = bus_en && bus_we && bus_addr == C_UNBLK;
  assign w_blk   = bus_en && bus_we && bus_addr == C_BLK;
  assign w_sts   = bus_en && bus_we && bus_addr == C_STATUS;
  assign d       = bus_wdata[NPINS-1:0];

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !w_sts |=> ((($past(sts)) & ~sts) == '0)); // R7
  AST_STS_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    w_sts |=> (($past(sts) & ~$past(d) & ~sts) == '0)); // R7
  AST_UNBLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    w_unblk |=> ((mask & $past(d)) == '0)); // R10
  AST_BLOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    w_blk |=> ((mask & $past(d)) == $past(d))); // R10
  AST_MASK_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_unblk || w_blk) |=> ((mask & ~$past(d)) == ($past(mask) & ~$past(d)))); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_unblk || w_blk) |=> $stable(mask)); // R2
  AST_ALL_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq); // R12
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0)); // R12
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK(BANK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sts(sts_q), .mask(mask_q), .irq(irq_o)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int NPINS = 32;
  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int BANK  = 1;
  localparam logic [AW-1:0] A_BLOCK  = AW'(32'h20C + 32'h40 * BANK);
  localparam logic [AW-1:0] A_UNBLK  = AW'(32'h210 + 32'h40 * BANK);
  localparam logic [AW-1:0] A_BLK    = AW'(32'h214 + 32'h40 * BANK);
  localparam logic [AW-1:0] A_STATUS = AW'(32'h218 + 32'h40 * BANK);
  localparam logic [AW-1:0] A_KIND   = AW'(32'h21C + 32'h40 * BANK);
  localparam logic [AW-1:0] A_SENSE  = AW'(32'h220 + 32'h40 * BANK);
  localparam logic [AW-1:0] A_DUAL   = AW'(32'h224 + 32'h40 * BANK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPINS-1:0] pins = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPINS(NPINS), .ADDR_W(AW), .DATA_W(DW), .BANK(BANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic drive(input logic [NPINS-1:0] v);
    @(negedge clk);
    pins = v;
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] k, input logic [31:0] s, input logic [31:0] du);
    wr(A_KIND, k); wr(A_SENSE, s); wr(A_DUAL, du);
    wr(A_STATUS, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(A_BLOCK, r);  check("R1 block", r, 32'hFFFF_FFFF);
    rd(A_STATUS, r); check("R1 status", r, 0);
    rd(A_KIND, r);   check("R1 kind", r, 32'hFFFF_FFFF);
    rd(A_SENSE, r);  check("R1 sense", r, 32'hFFFF_FFFF);
    rd(A_DUAL, r);   check("R1 dual", r, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(A_UNBLK, r);  check("R2 unblock port reads 0", r, 0);
    rd(A_BLK, r);    check("R2 block port reads 0", r, 0);
    wr(A_BLOCK, 32'h0);
    rd(A_BLOCK, r);  check("R2 block word write ignored", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_rising();
    logic [31:0] r;
    drive('0); setup('1, '1, '0);
    drive(32'h1);
    rd(A_STATUS, r); check("R3 rising sets", r, 32'h1);
    wr(A_STATUS, 32'h1);
    drive('0);
    rd(A_STATUS, r); check("R3 falling ignored", r, 0);
  endtask

  task automatic t_falling();
    logic [31:0] r;
    drive('0); setup('1, ~32'h2, '0);
    drive(32'h2);
    rd(A_STATUS, r); check("R4 rising ignored", r, 0);
    drive('0);
    rd(A_STATUS, r); check("R4 falling sets", r, 32'h2);
  endtask

  task automatic t_dual();
    logic [31:0] r;
    drive('0); setup('1, ~32'h4, 32'hC);
    drive(32'hC);
    rd(A_STATUS, r); check("R5 both-edge rise", r, 32'hC);
    wr(A_STATUS, 32'hC);
    drive('0);
    rd(A_STATUS, r); check("R5 both-edge fall", r, 32'hC);
  endtask

  task automatic t_level();
    logic [31:0] r;
    drive('0); setup(~32'h10, '1, 32'h10);
    @(negedge clk);
    rd(A_STATUS, r); check("R6 high level idle", r, 0);
    drive(32'h10);
    rd(A_STATUS, r); check("R6 high level sets", r, 32'h10);
    wr(A_STATUS, 32'h10);
    rd(A_STATUS, r); check("R8 level re-sets after clear", r, 32'h10);
    drive('0);
    wr(A_STATUS, 32'h10);
    rd(A_STATUS, r); check("R8 clear sticks once level gone", r, 0);
    drive(32'h20); setup(~32'h20, ~32'h20, '0);
    rd(A_STATUS, r); check("R6 low level idle while high", r, 0);
    drive('0);
    rd(A_STATUS, r); check("R6 low level sets", r, 32'h20);
  endtask

  task automatic t_w1c();
    logic [31:0] r;
    drive('0); setup('1, '1, '0);
    drive(32'h5);
    wr(A_STATUS, 32'h1);
    rd(A_STATUS, r); check("R7 only written ones clear", r, 32'h4);
  endtask

  task automatic t_same_cycle();
    logic [31:0] r;
    drive('0); setup('1, '1, '0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_STATUS; bus_wdata = 32'h80;
    pins = 32'h80;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(A_STATUS, r); check("R9 edge beats clear", r, 32'h80);
    wr(A_STATUS, 32'h80);
    rd(A_STATUS, r); check("R9 plain clear", r, 0);
  endtask

  task automatic t_block();
    logic [31:0] r;
    drive('0); setup('1, '1, '0);
    drive(32'h100);
    rd(A_STATUS, r); check("R11 latched while blocked", r, 32'h100);
    check("R12 blocked no irq", {31'b0, irq}, 0);
    wr(A_UNBLK, 32'h100);
    rd(A_BLOCK, r); check("R10 unblock clears bit", r, 32'hFFFF_FEFF);
    check("R11 irq on unblock", {31'b0, irq}, 1);
    wr(A_UNBLK, 32'h0);
    rd(A_BLOCK, r); check("R10 zero bits ignored", r, 32'hFFFF_FEFF);
    wr(A_BLK, 32'h100);
    rd(A_BLOCK, r); check("R10 block sets bit", r, 32'hFFFF_FFFF);
    check("R12 irq gated", {31'b0, irq}, 0);
    wr(A_UNBLK, 32'h100);
    wr(A_STATUS, 32'h100);
    check("R12 irq drops with status", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rising();
    t_falling();
    t_dual();
    t_level();
    t_w1c();
    t_same_cycle();
    t_block();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule